// File: doc/BRIEF.md
# Aggregate Boundary Status Tagger

This block sits on the receive side of a wireless MAC, beside the engine that writes frame data to memory. It watches a stream of boundary events, one per clock, which mark where a physical-layer burst, each MAC frame within it, and each sub-frame within that frame begin and end. A separate event kind reports each aggregation delimiter that follows a frame, together with that delimiter's checksum-error bit. From these events the block builds one status word per completed sub-frame. The word carries its position inside both aggregation levels, its index within the enclosing frame, the trailing delimiter count and a delimiter-error flag.

A sub-frame's status cannot be sent when the sub-frame ends. Its "last" flags depend on the next boundary event, so the block keeps one completed status word in a hold register. A later event releases it. The final word of a burst stays held while trailing delimiters are counted, and is released only by the burst-end event. A released word appears on the outputs one clock after the event that released it, with a single-cycle valid pulse and a done flag.

Top module: `agg_status_tagger`

## Requirements
- R1: After reset `stat_valid` and `stat_done` are low. No status word is emitted until a sub-frame has completed and a later event releases it.
- R2: `stat_first_mpdu` is 1 only on the first sub-frame completed after a burst-start event (code 1), and 0 on every other word.
- R3: `stat_last_mpdu` is 1 only on a word released by a burst-end event (code 2), and 0 on words released by any other event. A word with both first and last frame flags set is a standalone frame.
- R4: `stat_first_msdu` is 1 only on the first sub-frame after a frame-start event (code 3). `stat_last_msdu` is 1 only when a frame-end event (code 4) came after the sub-frame's end event (code 6) and before its release. Interior sub-frames have both flags at 0.
- R5: `stat_msdu_num` is 0 for the first sub-frame of each frame and increases by one for each later sub-frame, wrapping modulo 2^NUM_W (256 by default).
- R6: Delimiter events (code 7) are counted only while the held word already has its frame end (R4). The count is reported in `stat_delim_cnt` only on a word with `stat_last_mpdu` set, and is 0 on all other words. The count saturates at 2^CNT_W-1 (4095 by default).
- R7: `stat_delim_err` is the OR of the `ev_delim_err` bits of the delimiters counted for that word (R6). It is reported on any word whose frame end was seen, whether or not the word is the burst's last.
- R8: While the final word of a burst waits for trailing delimiters, no status is emitted. The burst-end event releases it. With no delimiters pending, the word is released at once with a count of 0.
- R9: A releasing event in clock cycle k gives `stat_valid` and `stat_done` high for exactly cycle k+1. `stat_done` is never high without `stat_valid`.
- R10: The following have no effect on the output: cycles with `ev_valid` low, event code 0, and delimiters that arrive while no held word has its frame end. A burst-start event discards any held word without emitting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event strobe, one event per cycle |
| ev_kind | input | 3 | Event code: 1 burst start, 2 burst end, 3 frame start, 4 frame end, 5 sub-frame start, 6 sub-frame end, 7 delimiter, 0 none |
| ev_delim_err | input | 1 | Checksum-error bit of a delimiter event |
| stat_valid | output | 1 | One-cycle pulse marking a released status word |
| stat_first_mpdu | output | 1 | First sub-frame of the burst |
| stat_last_mpdu | output | 1 | Final sub-frame of the burst |
| stat_first_msdu | output | 1 | First sub-frame of its frame |
| stat_last_msdu | output | 1 | Final sub-frame of its frame |
| stat_msdu_num | output | NUM_W | Sub-frame index within the frame |
| stat_delim_cnt | output | CNT_W | Trailing delimiter count, burst-final word only |
| stat_delim_err | output | 1 | A counted delimiter had a checksum error |
| stat_done | output | 1 | All fields of the word are complete |

## Verification
The assertions check on every cycle the relations that hold for any event sequence. Done never appears without valid, and an idle cycle is never followed by output. A burst-final word needs a burst-end event in the cycle before it. A delimiter count appears only on a burst-final word, and the index is zero whenever the first-of-frame flag is set. The assertions cannot show that the correct word was held, or that first and last flags fall on the right sub-frames across nested frames. Nor can they show index wrap, count saturation, or that a word is discarded when a burst starts again. The bench scenarios cover these by comparing each cycle's output with a sequence model. The scenarios include long sub-frame runs, more than four thousand trailing delimiters and out-of-order bursts.

// File: rtl/abst_pkg.sv
package abst_pkg;

   typedef enum logic [2:0] {
      EV_NONE        = 3'd0,
      EV_BURST_START = 3'd1,
      EV_BURST_END   = 3'd2,
      EV_FRAME_START = 3'd3,
      EV_FRAME_END   = 3'd4,
      EV_SUB_START   = 3'd5,
      EV_SUB_END     = 3'd6,
      EV_DELIM       = 3'd7
   } ev_kind_e;

   typedef struct packed {
      logic burst_start;
      logic burst_end;
      logic frame_start;
      logic frame_end;
      logic sub_start;
      logic sub_end;
      logic delim;
   } ev_hit_t;

endpackage

// File: rtl/abst_event_decode.sv
module abst_event_decode
   import abst_pkg::*;
(
   input  logic       ev_valid,
   input  logic [2:0] ev_kind,
   output ev_hit_t    hit
);

   always_comb begin
      hit = '0;
      if (ev_valid) begin
         case (ev_kind_e'(ev_kind))
            EV_BURST_START: hit.burst_start = 1'b1;
            EV_BURST_END:   hit.burst_end   = 1'b1;
            EV_FRAME_START: hit.frame_start = 1'b1;
            EV_FRAME_END:   hit.frame_end   = 1'b1;
            EV_SUB_START:   hit.sub_start   = 1'b1;
            EV_SUB_END:     hit.sub_end     = 1'b1;
            EV_DELIM:       hit.delim       = 1'b1;
            default:        hit             = '0;
         endcase
      end
   end

endmodule

// File: rtl/abst_position_track.sv
module abst_position_track
   import abst_pkg::*;
#(
   parameter int NUM_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  ev_hit_t          hit,
   output logic             burst_first,
   output logic             frame_first,
   output logic [NUM_W-1:0] sub_index
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_first <= 1'b1;
         frame_first <= 1'b1;
         sub_index   <= '0;
      end else if (hit.burst_start) begin
         burst_first <= 1'b1;
         frame_first <= 1'b1;
         sub_index   <= '0;
      end else if (hit.frame_start) begin
         frame_first <= 1'b1;
         sub_index   <= '0;
      end else if (hit.sub_end) begin
         burst_first <= 1'b0;
         frame_first <= 1'b0;
         sub_index   <= sub_index + 1'b1;
      end
   end

endmodule

// File: rtl/abst_hold_stage.sv
module abst_hold_stage
   import abst_pkg::*;
#(
   parameter int NUM_W    = 8,
   parameter int CNT_W    = 12,
   parameter bit SATURATE = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  ev_hit_t          hit,
   input  logic             delim_err,
   input  logic             burst_first,
   input  logic             frame_first,
   input  logic [NUM_W-1:0] sub_index,
   output logic             rel,
   output logic             rel_first_mpdu,
   output logic             rel_last_mpdu,
   output logic             rel_first_msdu,
   output logic             rel_last_msdu,
   output logic [NUM_W-1:0] rel_num,
   output logic [CNT_W-1:0] rel_cnt,
   output logic             rel_err
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic             h_vld;
   logic             h_fmp;
   logic             h_fms;
   logic             h_lms;
   logic [NUM_W-1:0] h_num;
   logic [CNT_W-1:0] h_cnt;
   logic             h_err;
   logic [CNT_W-1:0] cnt_next;
   logic             releaser;
   logic             counting;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_next = (h_cnt == CNT_TOP) ? h_cnt : h_cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_next = h_cnt + 1'b1;
      end
   endgenerate

   assign releaser = hit.sub_start | hit.frame_start | hit.sub_end | hit.burst_end;
   assign counting = h_vld & h_lms & hit.delim;

   always_comb begin
      rel            = h_vld & releaser;
      rel_first_mpdu = h_fmp;
      rel_first_msdu = h_fms;
      rel_last_msdu  = h_lms;
      rel_last_mpdu  = hit.burst_end;
      rel_num        = h_num;
      rel_cnt        = hit.burst_end ? h_cnt : '0;
      rel_err        = h_lms & h_err;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_vld <= 1'b0;
         h_fmp <= 1'b0;
         h_fms <= 1'b0;
         h_lms <= 1'b0;
         h_num <= '0;
         h_cnt <= '0;
         h_err <= 1'b0;
      end else if (hit.burst_start) begin
         h_vld <= 1'b0;
      end else if (hit.sub_end) begin
         h_vld <= 1'b1;
         h_fmp <= burst_first;
         h_fms <= frame_first;
         h_lms <= 1'b0;
         h_num <= sub_index;
         h_cnt <= '0;
         h_err <= 1'b0;
      end else if (releaser) begin
         h_vld <= 1'b0;
      end else if (hit.frame_end && h_vld) begin
         h_lms <= 1'b1;
      end else if (counting) begin
         h_cnt <= cnt_next;
         h_err <= h_err | delim_err;
      end
   end

endmodule

// File: rtl/agg_status_tagger.sv
module agg_status_tagger
   import abst_pkg::*;
#(
   parameter int NUM_W    = 8,
   parameter int CNT_W    = 12,
   parameter bit SATURATE = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   input  logic [2:0]       ev_kind,
   input  logic             ev_delim_err,
   output logic             stat_valid,
   output logic             stat_first_mpdu,
   output logic             stat_last_mpdu,
   output logic             stat_first_msdu,
   output logic             stat_last_msdu,
   output logic [NUM_W-1:0] stat_msdu_num,
   output logic [CNT_W-1:0] stat_delim_cnt,
   output logic             stat_delim_err,
   output logic             stat_done
);

   generate
      if (NUM_W < 1 || NUM_W > 16) begin : g_bad_num
         $error("agg_status_tagger: NUM_W must lie in 1..16");
      end
      if (CNT_W < 2 || CNT_W > 24) begin : g_bad_cnt
         $error("agg_status_tagger: CNT_W must lie in 2..24");
      end
   endgenerate

   ev_hit_t          hit;
   logic             burst_first;
   logic             frame_first;
   logic [NUM_W-1:0] sub_index;
   logic             rel;
   logic             rel_first_mpdu;
   logic             rel_last_mpdu;
   logic             rel_first_msdu;
   logic             rel_last_msdu;
   logic [NUM_W-1:0] rel_num;
   logic [CNT_W-1:0] rel_cnt;
   logic             rel_err;

   abst_event_decode u_dec (
      .ev_valid (ev_valid),
      .ev_kind  (ev_kind),
      .hit      (hit)
   );

   abst_position_track #(.NUM_W(NUM_W)) u_pos (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit),
      .burst_first (burst_first),
      .frame_first (frame_first),
      .sub_index   (sub_index)
   );

   abst_hold_stage #(.NUM_W(NUM_W), .CNT_W(CNT_W), .SATURATE(SATURATE)) u_hold (
      .clk            (clk),
      .rst_n          (rst_n),
      .hit            (hit),
      .delim_err      (ev_delim_err),
      .burst_first    (burst_first),
      .frame_first    (frame_first),
      .sub_index      (sub_index),
      .rel            (rel),
      .rel_first_mpdu (rel_first_mpdu),
      .rel_last_mpdu  (rel_last_mpdu),
      .rel_first_msdu (rel_first_msdu),
      .rel_last_msdu  (rel_last_msdu),
      .rel_num        (rel_num),
      .rel_cnt        (rel_cnt),
      .rel_err        (rel_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_valid      <= 1'b0;
         stat_done       <= 1'b0;
         stat_first_mpdu <= 1'b0;
         stat_last_mpdu  <= 1'b0;
         stat_first_msdu <= 1'b0;
         stat_last_msdu  <= 1'b0;
         stat_msdu_num   <= '0;
         stat_delim_cnt  <= '0;
         stat_delim_err  <= 1'b0;
      end else begin
         stat_valid <= rel;
         stat_done  <= rel;
         if (rel) begin
            stat_first_mpdu <= rel_first_mpdu;
            stat_last_mpdu  <= rel_last_mpdu;
            stat_first_msdu <= rel_first_msdu;
            stat_last_msdu  <= rel_last_msdu;
            stat_msdu_num   <= rel_num;
            stat_delim_cnt  <= rel_cnt;
            stat_delim_err  <= rel_err;
         end
      end
   end

endmodule

// File: rtl/agg_status_tagger_chk.sv
module agg_status_tagger_chk #(
   parameter int NUM_W = 8,
   parameter int CNT_W = 12
)(
   input logic             clk,
   input logic             rst_n,
   input logic             ev_valid,
   input logic [2:0]       ev_kind,
   input logic             stat_valid,
   input logic             stat_first_msdu,
   input logic             stat_last_mpdu,
   input logic [NUM_W-1:0] stat_msdu_num,
   input logic [CNT_W-1:0] stat_delim_cnt,
   input logic             stat_done
);

   assert_done_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_done |-> stat_valid);

   assert_idle_no_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_valid |=> !stat_valid);

   assert_final_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_last_mpdu) |-> ($past(ev_valid) && $past(ev_kind) == 3'd2));

   assert_count_final_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && !stat_last_mpdu) |-> (stat_delim_cnt == '0));

   assert_first_index_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_first_msdu) |-> (stat_msdu_num == '0));

endmodule

bind agg_status_tagger agg_status_tagger_chk #(.NUM_W(NUM_W), .CNT_W(CNT_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .ev_valid        (ev_valid),
   .ev_kind         (ev_kind),
   .stat_valid      (stat_valid),
   .stat_first_msdu (stat_first_msdu),
   .stat_last_mpdu  (stat_last_mpdu),
   .stat_msdu_num   (stat_msdu_num),
   .stat_delim_cnt  (stat_delim_cnt),
   .stat_done       (stat_done)
);

// File: tb/tb_agg_status_tagger.sv
module tb_agg_status_tagger;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_W = 8;
   localparam int CNT_W = 12;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ev_valid = 1'b0;
   logic [2:0]       ev_kind = 3'd0;
   logic             ev_delim_err = 1'b0;
   logic             stat_valid;
   logic             stat_first_mpdu;
   logic             stat_last_mpdu;
   logic             stat_first_msdu;
   logic             stat_last_msdu;
   logic [NUM_W-1:0] stat_msdu_num;
   logic [CNT_W-1:0] stat_delim_cnt;
   logic             stat_delim_err;
   logic             stat_done;

   int checks = 0;
   int fails  = 0;

   // sequence model state
   bit m_bfirst = 1, m_ffirst = 1;
   int m_idx = 0;
   bit m_hv = 0, m_hfmp = 0, m_hfms = 0, m_hlms = 0, m_herr = 0;
   int m_hnum = 0, m_hcnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   agg_status_tagger #(.NUM_W(NUM_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_delim_err(ev_delim_err), .stat_valid(stat_valid),
      .stat_first_mpdu(stat_first_mpdu), .stat_last_mpdu(stat_last_mpdu),
      .stat_first_msdu(stat_first_msdu), .stat_last_msdu(stat_last_msdu),
      .stat_msdu_num(stat_msdu_num), .stat_delim_cnt(stat_delim_cnt),
      .stat_delim_err(stat_delim_err), .stat_done(stat_done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit is_rel(input bit v, input int k);
      return v && m_hv && (k == 5 || k == 3 || k == 6 || k == 2);
   endfunction

   task automatic send(input bit v, input int k, input bit err, input string vtag);
      bit rel;
      bit e_fmp, e_lmp, e_fms, e_lms, e_err;
      int e_num, e_cnt;
      rel   = is_rel(v, k);
      e_fmp = m_hfmp; e_fms = m_hfms; e_lms = m_hlms;
      e_lmp = (k == 2);
      e_num = m_hnum;
      e_cnt = (k == 2) ? m_hcnt : 0;
      e_err = m_hlms & m_herr;
      // model update
      if (v) begin
         if (k == 1) begin
            m_hv = 0; m_bfirst = 1; m_ffirst = 1; m_idx = 0;
         end else if (k == 6) begin
            m_hv = 1; m_hfmp = m_bfirst; m_hfms = m_ffirst; m_hlms = 0;
            m_hnum = m_idx; m_hcnt = 0; m_herr = 0;
            m_bfirst = 0; m_ffirst = 0; m_idx = (m_idx + 1) % (1 << NUM_W);
         end else if (k == 5 || k == 2) begin
            m_hv = 0;
         end else if (k == 3) begin
            m_hv = 0; m_ffirst = 1; m_idx = 0;
         end else if (k == 4) begin
            if (m_hv) m_hlms = 1;
         end else if (k == 7) begin
            if (m_hv && m_hlms) begin
               if (m_hcnt < CNT_MAX) m_hcnt++;
               m_herr = m_herr | err;
            end
         end
      end
      @(negedge clk);
      ev_valid = v; ev_kind = 3'(k); ev_delim_err = err;
      @(posedge clk);
      #1;
      chk(vtag, int'(stat_valid), int'(rel));
      chk("R9", int'(stat_done), int'(rel));
      if (rel) begin
         chk("R2", int'(stat_first_mpdu), int'(e_fmp));
         chk("R3", int'(stat_last_mpdu), int'(e_lmp));
         chk("R4", int'(stat_first_msdu), int'(e_fms));
         chk("R4", int'(stat_last_msdu), int'(e_lms));
         chk("R5", int'(stat_msdu_num), e_num);
         chk("R6", int'(stat_delim_cnt), e_cnt);
         chk("R7", int'(stat_delim_err), int'(e_err));
      end
      @(negedge clk);
      ev_valid = 0; ev_kind = 3'd0; ev_delim_err = 0;
   endtask

   task automatic ev(input int k);
      send(1'b1, k, 1'b0, "R9");
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      chk("R1", int'(stat_valid), 0);
      chk("R1", int'(stat_done), 0);
      @(negedge clk);
      rst_n = 1'b1;
      send(1'b0, 0, 1'b0, "R1");

      // standalone frame, single sub-frame, no delimiters (R3, R8)
      ev(1); ev(3); ev(5); ev(6); ev(4);
      send(1'b1, 2, 1'b0, "R8");

      // held word waits for delimiters: no output until burst end (R8, R7)
      ev(1); ev(3); ev(5); ev(6); ev(4);
      send(1'b1, 7, 1'b0, "R8");
      send(1'b1, 7, 1'b1, "R8");
      send(1'b1, 7, 1'b0, "R8");
      send(1'b1, 2, 1'b0, "R8");

      // ignored stimulus: idle, code 0, stray delimiters (R10)
      ev(1); ev(3); ev(5);
      send(1'b1, 7, 1'b1, "R10");
      send(1'b1, 0, 1'b1, "R10");
      ev(6);
      send(1'b0, 2, 1'b0, "R10");
      send(1'b1, 7, 1'b1, "R10");
      ev(4); ev(2);
      // burst start discards held word (R10)
      ev(1); ev(3); ev(5); ev(6); ev(4);
      send(1'b1, 1, 1'b0, "R10");
      send(1'b1, 2, 1'b0, "R10");

      // index wrap with 300 sub-frames (R5)
      ev(1); ev(3);
      for (int i = 0; i < 300; i++) begin
         ev(5); ev(6);
      end
      ev(4); ev(2);

      // delimiter count saturation (R6)
      ev(1); ev(3); ev(5); ev(6); ev(4);
      for (int i = 0; i < CNT_MAX + 5; i++) send(1'b1, 7, 1'b0, "R6");
      ev(2);

      // constrained random bursts
      for (int b = 0; b < 150; b++) begin
         int nf;
         nf = 1 + int'($urandom % 4);
         ev(1);
         for (int f = 0; f < nf; f++) begin
            int ns, nd;
            ns = 1 + int'($urandom % 4);
            ev(3);
            for (int s = 0; s < ns; s++) begin
               ev(5);
               if ($urandom % 4 == 0) send(1'b0, 0, 1'b0, "R10");
               ev(6);
            end
            ev(4);
            nd = int'($urandom % 6);
            for (int d = 0; d < nd; d++) send(1'b1, 7, 1'($urandom % 3 == 0), "R7");
         end
         ev(2);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule